// File: doc/BRIEF.md
# Translation Buffer with Changed-Flag Write-Back

This block is a small fully associative translation buffer. Each slot holds a virtual page tag, a physical page number, two protection bits, a changed flag and the memory address of the page table entry it was copied from. A requester presents a virtual page, says whether the access is a store, and marks with a commit strobe that the store is certain to go ahead. In the same cycle the block returns hit, physical page, referenced and changed flags, and a protection fault.

A committed store is permitted when it hits a writable slot. If that slot is clean, the buffer does not just mark its local copy. It stalls the requester and runs a read-modify-write of the in-memory page table entry that forces the changed bit to 1. It then sets the changed flag in its own slot. The update is driven by a five-state machine. IDLE moves to READ_PTE when a committed permitted store hits a clean slot. READ_PTE issues the read request and moves to WRITE_PTE once the read data strobe arrives. WRITE_PTE holds the write request and moves to RELOAD when the request is accepted. RELOAD sets the slot's changed flag and moves to DONE. DONE returns to IDLE.

Slots are loaded by a software write port and cleared by an invalidate input. The block does no table walk and no refill, so a lookup that misses is only reported.

Top module: `tlb_cbit_ctrl`

## Requirements
- R1: A lookup with `lk_valid` high hits when exactly one valid slot's tag equals `lk_vpn`, and then returns that slot's physical page on `lk_ppn`. No match, or two or more matches, gives `lk_hit` = 0.
- R2: `lk_ref` is 1 on every hit and 0 on a miss. A slot is only ever present because its page was referenced, and the block never clears the flag on its own.
- R3: `sw_prot` bit 0 permits loads and bit 1 permits stores. `lk_fault` is 1 in the lookup cycle when a hit is not permitted for its access type. It is 0 on a miss.
- R4: A lookup that has `lk_valid`, `lk_store` and `lk_commit` high and hits a store-permitted slot whose changed flag is 0 raises `lk_stall` in that same cycle. The stall stays high through READ_PTE, WRITE_PTE and RELOAD, which is at least three further cycles, and is low in DONE.
- R5: A committed store that hits a slot whose changed flag is already 1 does not stall and issues no memory request.
- R6: A committed store that faults stalls nothing, issues no memory request and leaves the slot's changed flag at 0.
- R7: The update first issues a read (`mem_req_we` = 0) at the slot's entry address. Only after `mem_rvalid` returns does it issue one write to the same address. The write data is the returned 32-bit word with bit 7 forced to 1 and every other bit unchanged.
- R8: From DONE onward the updated slot reports `lk_chg` = 1. A later committed store to it runs no further update.
- R9: `inval` clears every slot when the machine is in IDLE, including the first cycle after DONE. It is ignored in READ_PTE through DONE.
- R10: `sw_we` loads slot `sw_idx` with tag, page, protection, changed flag and entry address, and marks it valid, when the machine is in IDLE. It is ignored in every other state.
- R11: A store without `lk_commit`, or any load, never starts an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_store | input | 1 | Access is a store (0 = load) |
| lk_commit | input | 1 | Store is certain to proceed |
| lk_hit | output | 1 | Exactly one slot matched |
| lk_ppn | output | PPN_W | Physical page of the matching slot |
| lk_ref | output | 1 | Referenced flag of the matching slot |
| lk_chg | output | 1 | Changed flag of the matching slot |
| lk_fault | output | 1 | Access not permitted by protection bits |
| lk_stall | output | 1 | Requester must hold; changed-flag update running |
| inval | input | 1 | Clear every slot |
| sw_we | input | 1 | Software slot write |
| sw_idx | input | clog2(ENTRIES) | Slot to write |
| sw_vpn | input | VPN_W | Tag to load |
| sw_ppn | input | PPN_W | Physical page to load |
| sw_prot | input | 2 | Bit 0 load permit, bit 1 store permit |
| sw_chg | input | 1 | Changed flag to load |
| sw_pte_addr | input | ADDR_W | Memory address of the page table entry |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Request address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid, one cycle |
| mem_rdata | input | DATA_W | Read data |

## Verification
The bench goes after the write-back sequence under random request-ready and read latency. A design that wrote before the read data came back, altered bits other than bit 7, or dropped the stall early would show a wrong memory word, a wrong write count or too short a stall. It pokes invalidate and slot writes into the busy window, where a design that accepted them would lose or corrupt slots, and then invalidates on the first cycle after DONE, where a design that ignored it would still hit. It also covers duplicate tags, which a careless priority encoder would report as a hit. It covers faulting stores and uncommitted stores, which must leave memory untouched and the changed flag clear.

// File: rtl/tlb_cb_pkg.sv
package tlb_cb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PTE,
        ST_WRITE_PTE,
        ST_RELOAD,
        ST_DONE
    } upd_state_t;

    localparam int PROT_LD = 0;
    localparam int PROT_ST = 1;
endpackage

// File: rtl/tlb_cb_array.sv
module tlb_cb_array #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inval,
    input  logic              sw_we,
    input  logic [IDX_W-1:0]  sw_idx,
    input  logic [VPN_W-1:0]  sw_vpn,
    input  logic [PPN_W-1:0]  sw_ppn,
    input  logic [1:0]        sw_prot,
    input  logic              sw_chg,
    input  logic [ADDR_W-1:0] sw_pte_addr,
    input  logic              set_chg,
    input  logic [IDX_W-1:0]  set_idx,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_idx,
    output logic [PPN_W-1:0]  hit_ppn,
    output logic [1:0]        hit_prot,
    output logic              hit_chg,
    output logic [ADDR_W-1:0] hit_pte_addr
);
    logic [ENTRIES-1:0] valid_q;
    logic [ENTRIES-1:0] chg_q;
    logic [VPN_W-1:0]   vpn_q  [ENTRIES];
    logic [PPN_W-1:0]   ppn_q  [ENTRIES];
    logic [1:0]         prot_q [ENTRIES];
    logic [ADDR_W-1:0]  pte_q  [ENTRIES];
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
                chg_q[g]   <= 1'b0;
                vpn_q[g]   <= '0;
                ppn_q[g]   <= '0;
                prot_q[g]  <= '0;
                pte_q[g]   <= '0;
            end else if (inval) begin
                valid_q[g] <= 1'b0;
            end else if (sw_we && sw_idx == IDX_W'(g)) begin
                valid_q[g] <= 1'b1;
                chg_q[g]   <= sw_chg;
                vpn_q[g]   <= sw_vpn;
                ppn_q[g]   <= sw_ppn;
                prot_q[g]  <= sw_prot;
                pte_q[g]   <= sw_pte_addr;
            end else if (set_chg && set_idx == IDX_W'(g)) begin
                chg_q[g]   <= 1'b1;
            end
        end
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit          = ($countones(match) == 1);
    assign hit_ppn      = ppn_q[hit_idx];
    assign hit_prot     = prot_q[hit_idx];
    assign hit_chg      = chg_q[hit_idx];
    assign hit_pte_addr = pte_q[hit_idx];
endmodule

// File: rtl/tlb_cb_upd.sv
module tlb_cb_upd
    import tlb_cb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CHG_BIT = 7,
    parameter int IDX_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_req_ready,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic              hold,
    output logic              set_chg,
    output logic [IDX_W-1:0]  set_idx,
    output logic              mem_req_valid,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [DATA_W-1:0] mem_req_wdata
);
    localparam logic [DATA_W-1:0] CHG_MASK = DATA_W'(1) << CHG_BIT;

    upd_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] word_q;
    logic              rd_sent_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = ST_READ_PTE;
            ST_READ_PTE:  if (rd_sent_q && mem_rvalid) state_d = ST_WRITE_PTE;
            ST_WRITE_PTE: if (mem_req_ready) state_d = ST_RELOAD;
            ST_RELOAD:    state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            addr_q    <= '0;
            idx_q     <= '0;
            word_q    <= '0;
            rd_sent_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                addr_q    <= start_addr;
                idx_q     <= start_idx;
                rd_sent_q <= 1'b0;
            end
            if (state_q == ST_READ_PTE && !rd_sent_q && mem_req_ready)
                rd_sent_q <= 1'b1;
            if (state_q == ST_READ_PTE && rd_sent_q && mem_rvalid)
                word_q <= mem_rdata;
        end
    end

    always_comb begin
        busy          = 1'b1;
        hold          = 1'b0;
        set_chg       = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        unique case (state_q)
            ST_IDLE:      busy = 1'b0;
            ST_READ_PTE:  begin hold = 1'b1; mem_req_valid = !rd_sent_q; end
            ST_WRITE_PTE: begin hold = 1'b1; mem_req_valid = 1'b1; mem_req_we = 1'b1; end
            ST_RELOAD:    begin hold = 1'b1; set_chg = 1'b1; end
            ST_DONE:      ;
            default:      busy = 1'b0;
        endcase
    end

    assign set_idx       = idx_q;
    assign mem_req_addr  = addr_q;
    assign mem_req_wdata = word_q | CHG_MASK;
endmodule

// File: rtl/tlb_cbit_ctrl.sv
module tlb_cbit_ctrl
    import tlb_cb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CHG_BIT = 7
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       lk_valid,
    input  logic [VPN_W-1:0]           lk_vpn,
    input  logic                       lk_store,
    input  logic                       lk_commit,
    output logic                       lk_hit,
    output logic [PPN_W-1:0]           lk_ppn,
    output logic                       lk_ref,
    output logic                       lk_chg,
    output logic                       lk_fault,
    output logic                       lk_stall,
    input  logic                       inval,
    input  logic                       sw_we,
    input  logic [$clog2(ENTRIES)-1:0] sw_idx,
    input  logic [VPN_W-1:0]           sw_vpn,
    input  logic [PPN_W-1:0]           sw_ppn,
    input  logic [1:0]                 sw_prot,
    input  logic                       sw_chg,
    input  logic [ADDR_W-1:0]          sw_pte_addr,
    output logic                       mem_req_valid,
    input  logic                       mem_req_ready,
    output logic                       mem_req_we,
    output logic [ADDR_W-1:0]          mem_req_addr,
    output logic [DATA_W-1:0]          mem_req_wdata,
    input  logic                       mem_rvalid,
    input  logic [DATA_W-1:0]          mem_rdata
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic              busy, hold, set_chg, start;
    logic [IDX_W-1:0]  set_idx, hit_idx;
    logic              arr_hit, hit_chg;
    logic [PPN_W-1:0]  hit_ppn;
    logic [1:0]        hit_prot;
    logic [ADDR_W-1:0] hit_pte_addr;
    logic              permit;

    tlb_cb_array #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
        .ADDR_W(ADDR_W), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .inval(inval && !busy),
        .sw_we(sw_we && !busy),
        .sw_idx(sw_idx), .sw_vpn(sw_vpn), .sw_ppn(sw_ppn),
        .sw_prot(sw_prot), .sw_chg(sw_chg), .sw_pte_addr(sw_pte_addr),
        .set_chg(set_chg), .set_idx(set_idx),
        .lk_vpn(lk_vpn),
        .hit(arr_hit), .hit_idx(hit_idx), .hit_ppn(hit_ppn),
        .hit_prot(hit_prot), .hit_chg(hit_chg), .hit_pte_addr(hit_pte_addr)
    );

    assign lk_hit   = lk_valid && arr_hit;
    assign permit   = lk_store ? hit_prot[PROT_ST] : hit_prot[PROT_LD];
    assign lk_fault = lk_hit && !permit;
    assign lk_ref   = lk_hit;
    assign lk_chg   = lk_hit && hit_chg;
    assign lk_ppn   = lk_hit ? hit_ppn : '0;
    assign start    = !busy && lk_hit && lk_store && lk_commit && permit && !hit_chg;
    assign lk_stall = start || hold;

    tlb_cb_upd #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHG_BIT(CHG_BIT), .IDX_W(IDX_W)
    ) u_upd (
        .clk(clk), .rst_n(rst_n),
        .start(start), .start_idx(hit_idx), .start_addr(hit_pte_addr),
        .mem_req_ready(mem_req_ready), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .busy(busy), .hold(hold), .set_chg(set_chg), .set_idx(set_idx),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
    );
endmodule

// File: rtl/tlb_cb_chk.sv
module tlb_cb_chk #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int CHG_BIT = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_fault,
    input logic              lk_stall,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_we,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [DATA_W-1:0] mem_req_wdata,
    input logic              mem_rvalid,
    input logic [DATA_W-1:0] mem_rdata
);
    logic              got_rd;
    logic [DATA_W-1:0] rd_word;
    logic [ADDR_W-1:0] rd_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_rd  <= 1'b0;
            rd_word <= '0;
            rd_addr <= '0;
        end else begin
            if (mem_rvalid) begin
                got_rd  <= 1'b1;
                rd_word <= mem_rdata;
            end
            if (mem_req_valid && mem_req_ready && !mem_req_we) rd_addr <= mem_req_addr;
            if (mem_req_valid && mem_req_ready && mem_req_we) got_rd <= 1'b0;
        end
    end

    // R7: write only after read data has returned
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> got_rd);

    // R7: write data is the read word with only the changed bit forced
    a_r7_write_data: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_wdata == (rd_word | (DATA_W'(1) << CHG_BIT))));

    // R7: write goes to the address that was read
    a_r7_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_addr == rd_addr));

    // R4: memory traffic only while the requester is stalled
    a_r4_mem_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> lk_stall);

    // R5: no stall this cycle means no request next cycle
    a_r5_quiet_after_nostall: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_stall |=> !mem_req_valid);

    // R6: faulting store without stall starts nothing
    a_r6_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_fault && !lk_stall) |=> !mem_req_valid);
endmodule

bind tlb_cbit_ctrl tlb_cb_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHG_BIT(CHG_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_fault(lk_fault), .lk_stall(lk_stall),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
);

// File: tb/tb_tlb_cbit_ctrl.sv
`timescale 1ns/1ps
module tb_tlb_cbit_ctrl;
    localparam int N = 8;
    localparam int VW = 20, PW = 20, AW = 32, DW = 32;

    logic clk = 0, rst_n = 0;
    always #4 clk = ~clk;

    logic          lk_valid = 0, lk_store = 0, lk_commit = 0;
    logic [VW-1:0] lk_vpn = '0;
    logic          lk_hit, lk_ref, lk_chg, lk_fault, lk_stall;
    logic [PW-1:0] lk_ppn;
    logic          inval = 0, sw_we = 0, sw_chg = 0;
    logic [2:0]    sw_idx = '0;
    logic [VW-1:0] sw_vpn = '0;
    logic [PW-1:0] sw_ppn = '0;
    logic [1:0]    sw_prot = '0;
    logic [AW-1:0] sw_pte_addr = '0;
    logic          mem_req_valid, mem_req_we, mem_rvalid = 0;
    logic          mem_req_ready = 0;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, mem_rdata = '0;

    tlb_cbit_ctrl dut (.*);

    // memory model
    logic [DW-1:0] mem_word [16];
    logic [DW-1:0] exp_mem  [16];
    int            rd_cnt = 0, wr_count = 0, req_count = 0;
    logic [3:0]    rd_idx = '0;

    always @(negedge clk) mem_req_ready <= ($urandom % 3) != 0;
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rd_cnt > 0) begin
            rd_cnt <= rd_cnt - 1;
            if (rd_cnt == 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem_word[rd_idx];
            end
        end
        if (rst_n && mem_req_valid && mem_req_ready) begin
            req_count <= req_count + 1;
            if (mem_req_we) begin
                mem_word[mem_req_addr[5:2]] <= mem_req_wdata;
                wr_count <= wr_count + 1;
            end else begin
                rd_idx <= mem_req_addr[5:2];
                rd_cnt <= 1 + ($urandom % 3);
            end
        end
    end

    // reference model
    logic          m_valid [N];
    logic [VW-1:0] m_vpn   [N];
    logic [PW-1:0] m_ppn   [N];
    logic [1:0]    m_prot  [N];
    logic          m_chg   [N];

    int n_chk = 0, n_fail = 0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int find(input logic [VW-1:0] v);
        int c = 0, k = -1;
        for (int i = 0; i < N; i++) if (m_valid[i] && m_vpn[i] == v) begin c++; k = i; end
        return (c == 1) ? k : -1;
    endfunction

    task automatic sw_load(input int idx, input logic [VW-1:0] v, input logic [PW-1:0] p,
                           input logic [1:0] pr, input logic c, input bit model);
        @(negedge clk);
        lk_valid = 0;
        sw_we = 1; sw_idx = 3'(idx); sw_vpn = v; sw_ppn = p; sw_prot = pr; sw_chg = c;
        sw_pte_addr = 32'h100 + 32'(idx * 4);
        @(posedge clk); #1 sw_we = 0;
        if (model) begin
            m_valid[idx] = 1; m_vpn[idx] = v; m_ppn[idx] = p; m_prot[idx] = pr; m_chg[idx] = c;
        end
    endtask

    // one lookup; runs the update to completion when a stall is expected
    task automatic lookup(input logic [VW-1:0] v, input logic st, input logic cm, input bit poke);
        int  k = find(v);
        logic eh = (k >= 0);
        logic perm, ef, es;
        int  w0, cyc;
        perm = eh && (st ? m_prot[k][1] : m_prot[k][0]);
        ef = eh && !perm;
        es = eh && st && cm && perm && !m_chg[k];
        @(negedge clk);
        lk_valid = 1; lk_vpn = v; lk_store = st; lk_commit = cm;
        #1;
        check("R1 hit", 64'(lk_hit), 64'(eh));
        if (eh) check("R1 ppn", 64'(lk_ppn), 64'(m_ppn[k]));
        check("R2 ref", 64'(lk_ref), 64'(eh));
        check("R8 chg", 64'(lk_chg), 64'(eh && m_chg[k]));
        check("R3 fault", 64'(lk_fault), 64'(ef));
        check(cm ? "R4 stall" : "R11 stall", 64'(lk_stall), 64'(es));
        if (es) begin
            w0 = wr_count; cyc = 0;
            for (int j = 0; j < 60; j++) begin
                @(negedge clk);
                if (poke && j == 0) begin
                    inval = 1; sw_we = 1; sw_idx = 3'd7; sw_vpn = 20'hFFFFF;
                    sw_ppn = 20'h12345; sw_prot = 2'b11; sw_chg = 0;
                end else begin
                    inval = 0; sw_we = 0;
                end
                #1;
                if (!lk_stall) break;
                cyc++;
            end
            inval = 0; sw_we = 0;
            check("R4 stall length", 64'(cyc >= 3), 64'(1));
            check("R8 chg after DONE", 64'(lk_chg), 64'(1));
            check("R7 one write", 64'(wr_count - w0), 64'(1));
            exp_mem[k] = exp_mem[k] | 32'h80;
            check("R7 memory word", 64'(mem_word[k]), 64'(exp_mem[k]));
            m_chg[k] = 1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int r0;
        void'($urandom(32'd4242));
        for (int i = 0; i < 16; i++) begin
            exp_mem[i] = $urandom & 32'hFFFF_FF7F;
            mem_word[i] = exp_mem[i];
        end
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        @(negedge clk);
        lk_valid = 1; lk_vpn = 20'h00100; lk_store = 1; lk_commit = 1;
        #1;
        check("R1 reset miss", 64'(lk_hit), 64'(0));
        check("R4 reset stall", 64'(lk_stall), 64'(0));
        check("R7 reset mem idle", 64'(mem_req_valid), 64'(0));

        for (int i = 0; i < N; i++)
            sw_load(i, 20'h00100 + 20'(i * 5), 20'hA0000 + 20'(i),
                    (i == 2) ? 2'b01 : (i == 3) ? 2'b00 : 2'b11, (i == 4), 1);

        // update with invalidate and slot write poked into busy window
        lookup(20'h00100, 1, 1, 1);
        lookup(20'hFFFFF, 0, 0, 0);               // R10 busy write ignored
        for (int i = 0; i < N; i++) lookup(m_vpn[i], 0, 0, 0);  // R9 busy inval ignored
        lookup(20'h00100, 1, 1, 0);               // R8/R5 dirty: no stall
        lookup(m_vpn[4], 1, 1, 0);                // R5 loaded dirty

        // R6 faulting committed store
        r0 = req_count;
        lookup(m_vpn[2], 1, 1, 0);
        lookup(m_vpn[3], 0, 1, 0);
        repeat (4) @(negedge clk);
        check("R6 no request", 64'(req_count - r0), 64'(0));
        lookup(m_vpn[2], 0, 0, 0);                // changed still 0

        // R11 uncommitted store
        r0 = req_count;
        lookup(m_vpn[1], 1, 0, 0);
        repeat (4) @(negedge clk);
        check("R11 no request", 64'(req_count - r0), 64'(0));

        // R1 duplicate tag
        sw_load(5, m_vpn[6], 20'h55555, 2'b11, 0, 1);
        lookup(m_vpn[6], 1, 1, 0);
        sw_load(5, 20'h00119, 20'hA0005, 2'b11, 0, 1);

        // random traffic
        for (int it = 0; it < 400; it++) begin
            int e = $urandom % N;
            if (($urandom % 8) == 0)
                sw_load(e, m_vpn[e], 20'($urandom), 2'($urandom), 0, 1);
            else
                lookup(($urandom % 5 == 0) ? 20'($urandom) : m_vpn[e],
                       1'($urandom), 1'($urandom), 0);
        end

        // R9 invalidate on first cycle after DONE
        sw_load(1, m_vpn[1], m_ppn[1], 2'b11, 0, 1);
        lookup(m_vpn[1], 1, 1, 0);
        @(negedge clk);
        lk_valid = 0; inval = 1;
        @(posedge clk); #1 inval = 0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            lk_valid = 1; lk_vpn = m_vpn[i]; lk_store = 0; lk_commit = 0;
            #1 check("R9 inval after DONE", 64'(lk_hit), 64'(0));
        end

        for (int i = 0; i < 16; i++) check("R7 final memory", 64'(mem_word[i]), 64'(exp_mem[i]));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule